// File: doc/BRIEF.md
# Inverted Page Table Address Translator

This block maps logical addresses to physical DRAM addresses through an inverted page table. The table holds one slot for each of the 128 physical pages. Each slot records which logical page is currently placed on that physical page, together with a two-bit protection level. A lookup presents a 25-bit logical address, a write flag and the requester's privilege mode. The block compares the logical page number against every slot in parallel. The index of the matching slot is the physical page number. The physical address is built from that index and the in-page offset, and the protection level of that slot decides whether the access may proceed.

The page size can be set to one of four sizes, from 4 KiB to 32 KiB. A larger page size leaves fewer logical page bits that take part in the compare, and it moves the physical page number further up the output address. Slots are programmed without a data bus. A store to the top eighth of a 26-bit bus address loads one slot, and the bus address itself carries the slot index, the logical page and the protection level. The result of each lookup appears one clock cycle after the request, either as a physical address or as an abort.

Top module: `ipt_xlate`

## Requirements
- R1: While `rst` is high and after it is released, every slot is invalid, so a lookup aborts until a slot has been written. `resp_valid` is low in the cycle after any cycle with `rst` high.
- R2: A write with `wr_en` high and `wr_addr[25:23]` = 3'b111 loads slot `wr_addr[6:0]`. The slot takes logical page `wr_addr[22:10]` and protection level `wr_addr[9:8]`, and is then valid. Bit 7 is ignored. A write with any other value in bits 25..23 changes nothing, and a rewrite of a slot replaces its previous mapping.
- R3: `pg_size` selects the page size as 0 = 4 KiB, 1 = 8 KiB, 2 = 16 KiB, 3 = 32 KiB. With shift s = 12 + pg_size, the request's logical page is `req_addr[24:s]`. Only the low 13 − pg_size bits of a slot's stored logical page take part in the compare.
- R4: On success, `resp_addr` = (slot index << s) | (`req_addr` mod 2^s), 22 bits wide.
- R5: Supervisor mode (`req_mode` = 2'b00) allows reads and writes at every protection level.
- R6: OS mode (`req_mode` = 2'b01) allows reads and writes at levels 0 and 1, and allows only reads at levels 2 and 3.
- R7: User mode (`req_mode` = 2'b10, and 2'b11 treated the same) allows reads and writes at level 0 and only reads at level 1. Levels 2 and 3 give no access at all.
- R8: A request that matches no valid slot, or that the protection rule refuses, returns `resp_abort` = 1 with `resp_addr` = 0.
- R9: When several valid slots match, the lowest-numbered slot wins, and its protection level alone governs the access.
- R10: `resp_valid` equals `req_valid` delayed by one cycle. A lookup issued in the same cycle as a slot write sees the table as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_size | input | 2 | Page size select |
| wr_en | input | 1 | Bus store strobe for slot programming |
| wr_addr | input | 26 | Store address carrying the slot contents |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 25 | Logical address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_mode | input | 2 | Privilege: 00 supervisor, 01 OS, 1x user |
| resp_valid | output | 1 | Lookup result present |
| resp_abort | output | 1 | Lookup refused (miss or protection) |
| resp_addr | output | 22 | Physical DRAM address, zero unless granted |

## Verification
The assertions assume that `pg_size` is held steady between a request and its response, because the offset and physical page fields move with it. The bench changes the page size only while `rst` is asserted and before any lookup. The checks on protection outcomes rely on the matcher's hit and on the protection level of the selected slot. These hold only if the table is not rewritten between request and response. The bench therefore programs slots only in cycles where no response is pending, with one exception: a single test that deliberately overlaps a write with a lookup.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int unsigned NUM_PAGES = 128;
    localparam int unsigned PPN_W     = $clog2(NUM_PAGES);
    localparam int unsigned LA_W      = 25;
    localparam int unsigned MIN_SHIFT = 12;
    localparam int unsigned LPN_W     = LA_W - MIN_SHIFT;
    localparam int unsigned PA_W      = PPN_W + MIN_SHIFT + 3;
    localparam int unsigned BUS_W     = 26;
    localparam int unsigned SH_W      = 4;
    localparam logic [2:0]  WIN_TAG   = 3'b111;

    typedef enum logic [1:0] {
        MODE_SUP  = 2'b00,
        MODE_OS   = 2'b01,
        MODE_USR  = 2'b10,
        MODE_USR2 = 2'b11
    } mode_e;

    typedef struct packed {
        logic             valid;
        logic [LPN_W-1:0] lpn;
        logic [1:0]       prot;
    } slot_t;

    function automatic logic [SH_W-1:0] page_shift(input logic [1:0] psz);
        return SH_W'(MIN_SHIFT) + {2'b00, psz};
    endfunction

    function automatic logic [LPN_W-1:0] lpn_mask(input logic [1:0] psz);
        return {LPN_W{1'b1}} >> psz;
    endfunction

    function automatic logic [LPN_W-1:0] req_lpn(input logic [LA_W-1:0] a,
                                                 input logic [1:0] psz);
        return LPN_W'(a >> page_shift(psz));
    endfunction

    function automatic logic access_ok(input mode_e m, input logic [1:0] lvl,
                                       input logic wr);
        case (m)
            MODE_SUP: return 1'b1;
            MODE_OS:  return (lvl < 2'd2) || !wr;
            default:  return (lvl == 2'd0) || ((lvl == 2'd1) && !wr);
        endcase
    endfunction

endpackage

// File: rtl/ipt_table.sv
module ipt_table
    import ipt_pkg::*;
#(
    parameter int unsigned ENTRIES = NUM_PAGES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [BUS_W-1:0]          wr_addr,
    output slot_t [ENTRIES-1:0]       slots_q
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic             wr_hit;
    logic [IDX_W-1:0] wr_idx;
    slot_t            wr_slot;

    assign wr_hit        = wr_en && (wr_addr[BUS_W-1:BUS_W-3] == WIN_TAG);
    assign wr_idx        = wr_addr[IDX_W-1:0];
    assign wr_slot.valid = 1'b1;
    assign wr_slot.lpn   = wr_addr[BUS_W-4:BUS_W-3-LPN_W];
    assign wr_slot.prot  = wr_addr[9:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else if (wr_hit) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) slots_q[i] <= wr_slot;
            end
        end
    end
endmodule

// File: rtl/ipt_match.sv
module ipt_match
    import ipt_pkg::*;
#(
    parameter int unsigned ENTRIES = NUM_PAGES
) (
    input  slot_t [ENTRIES-1:0]          slots,
    input  logic [LPN_W-1:0]             lpn,
    input  logic [1:0]                   psz,
    output logic                         hit,
    output logic [$clog2(ENTRIES)-1:0]   idx
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [LPN_W-1:0]   mask;
    logic [ENTRIES-1:0] eq;

    assign mask = lpn_mask(psz);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = slots[g].valid && ((slots[g].lpn & mask) == (lpn & mask));
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ipt_xlate.sv
module ipt_xlate
    import ipt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pg_size,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_addr,
    input  logic              req_valid,
    input  logic [LA_W-1:0]   req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    output logic              resp_valid,
    output logic              resp_abort,
    output logic [PA_W-1:0]   resp_addr
);
    slot_t [NUM_PAGES-1:0] slots;
    logic                  match_hit;
    logic [PPN_W-1:0]      match_idx;
    slot_t                 sel_slot;
    logic [1:0]            sel_prot;
    logic                  grant;
    logic [SH_W-1:0]       shift;
    logic [PA_W-1:0]       off_mask;
    logic [PA_W-1:0]       phys;

    ipt_table #(.ENTRIES(NUM_PAGES)) i_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .slots_q (slots)
    );

    ipt_match #(.ENTRIES(NUM_PAGES)) i_match (
        .slots (slots),
        .lpn   (req_lpn(req_addr, pg_size)),
        .psz   (pg_size),
        .hit   (match_hit),
        .idx   (match_idx)
    );

    assign sel_slot = slots[match_idx];
    assign sel_prot = sel_slot.prot;
    assign grant    = match_hit && access_ok(mode_e'(req_mode), sel_prot, req_write);
    assign shift    = page_shift(pg_size);
    assign off_mask = ~({PA_W{1'b1}} << shift);
    assign phys     = (PA_W'(match_idx) << shift) | (PA_W'(req_addr) & off_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_abort <= 1'b0;
            resp_addr  <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_abort <= req_valid && !grant;
            resp_addr  <= (req_valid && grant) ? phys : '0;
        end
    end
endmodule

// File: rtl/ipt_xlate_chk.sv
module ipt_xlate_chk
    import ipt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [LA_W-1:0] req_addr,
    input logic            req_write,
    input logic [1:0]      req_mode,
    input logic            resp_valid,
    input logic            resp_abort,
    input logic [PA_W-1:0] resp_addr,
    input logic            match_hit,
    input logic [1:0]      sel_prot
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !resp_valid);

    // R10
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (resp_valid == $past(req_valid)));

    // R8
    abort_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        resp_abort |-> (resp_valid && resp_addr == '0));

    // R8
    miss_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !match_hit) |=> resp_abort);

    // R4
    offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_abort) |-> (resp_addr[MIN_SHIFT-1:0] == $past(req_addr[MIN_SHIFT-1:0])));

    // R5
    sup_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'b00 && match_hit) |=> !resp_abort);

    // R7
    user_high_level_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode[1] && match_hit && sel_prot[1]) |=> resp_abort);
endmodule

bind ipt_xlate ipt_xlate_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_mode   (req_mode),
    .resp_valid (resp_valid),
    .resp_abort (resp_abort),
    .resp_addr  (resp_addr),
    .match_hit  (match_hit),
    .sel_prot   (sel_prot)
);

// File: tb/test_ipt_xlate.sv
`timescale 1ns/1ps
module test_ipt_xlate;
    localparam int NP = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  pg_size = 2'd0;
    logic        wr_en = 1'b0;
    logic [25:0] wr_addr = '0;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic        resp_valid, resp_abort;
    logic [21:0] resp_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit m_valid [NP];
    int m_lpn   [NP];
    int m_prot  [NP];

    always #2 clk = ~clk;

    ipt_xlate i_ipt_xlate (
        .clk(clk), .rst(rst), .pg_size(pg_size), .wr_en(wr_en), .wr_addr(wr_addr),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_mode(req_mode), .resp_valid(resp_valid), .resp_abort(resp_abort),
        .resp_addr(resp_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model(input int a, input int mode, input bit wr,
                                  output bit ab, output int pa);
        int sh = 12 + int'(pg_size);
        int msk = (1 << (13 - int'(pg_size))) - 1;
        int lp = a >> sh;
        int idx = -1;
        bit ok;
        for (int i = NP - 1; i >= 0; i--)
            if (m_valid[i] && ((m_lpn[i] & msk) == lp)) idx = i;
        if (idx < 0) ok = 0;
        else if (mode == 0) ok = 1;
        else if (mode == 1) ok = (m_prot[idx] < 2) || !wr;
        else ok = (m_prot[idx] == 0) || (m_prot[idx] == 1 && !wr);
        ab = !ok;
        pa = ok ? ((idx << sh) | (a & ((1 << sh) - 1))) : 0;
    endfunction

    task automatic do_reset(input int psz);
        @(negedge clk);
        rst = 1'b1;
        pg_size = 2'(psz);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NP; i++) m_valid[i] = 0;
        check(resp_valid == 1'b0, "R1 resp_valid after reset", int'(resp_valid), 0);
    endtask

    task automatic wr_slot(input int ppn, input int lpn, input int prot,
                           input int tag3, input int b7);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = {3'(tag3), 13'(lpn), 2'(prot), 1'(b7), 7'(ppn)};
        @(negedge clk);
        wr_en = 1'b0;
        if (tag3 == 7) begin
            m_valid[ppn] = 1;
            m_lpn[ppn] = lpn & 16'h1fff;
            m_prot[ppn] = prot;
        end
    endtask

    task automatic lookup(input int a, input int mode, input bit wr, input string tag);
        bit ab;
        int pa;
        model(a, mode, wr, ab, pa);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = 25'(a);
        req_mode = 2'(mode);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid == 1'b1 && resp_abort == ab && resp_addr == 22'(pa), tag,
              {resp_valid, resp_abort, 30'(resp_addr)}, {1'b1, ab, 30'(pa)});
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: empty table aborts
        do_reset(0);
        lookup(25'h0012345, 0, 0, "R1 empty table miss");
        @(negedge clk);
        check(resp_valid == 1'b0, "R10 resp_valid drops", int'(resp_valid), 0);

        // Sweep all page sizes: R3 R4 with the protection rules
        for (int s = 0; s < 4; s++) begin
            do_reset(s);
            for (int i = 0; i < NP; i++)
                wr_slot(i, ((i * 37 + 5) & 1023) | ((i & 7) << 10), i % 4, 7, i & 1);
            for (int i = 0; i < NP; i++) begin
                int sh = 12 + s;
                int msk = (1 << (13 - s)) - 1;
                int a = ((m_lpn[i] & msk) << sh) | ((i * 97 + 3) & ((1 << sh) - 1));
                for (int m = 0; m < 4; m++) begin
                    for (int w = 0; w < 2; w++) begin
                        if (m == 0) lookup(a, m, w[0], "R2 R3 R4 R5 supervisor");
                        else if (m == 1) lookup(a, m, w[0], "R2 R3 R4 R6 os");
                        else lookup(a, m, w[0], "R2 R3 R4 R7 user");
                    end
                end
            end
            // R8: an unmapped logical page
            for (int j = 0; j < 8192; j++) begin
                bit ab;
                int pa;
                model(j << (12 + s), 0, 0, ab, pa);
                if (ab) begin
                    lookup(j << (12 + s), 0, 0, "R8 unmapped page");
                    break;
                end
            end
        end

        // R2: write outside the programming window is ignored
        do_reset(3);
        wr_slot(5, 9, 0, 6, 0);
        lookup(9 << 15, 0, 0, "R2 foreign window ignored");
        // R3: upper stored bits ignored at 32 KiB
        wr_slot(6, 13'h1000 | 33, 0, 7, 0);
        lookup((33 << 15) | 16'h1234, 2, 1, "R3 upper lpn bits ignored");
        // R9: lowest slot wins
        wr_slot(20, 77, 2, 7, 0);
        wr_slot(3, 77, 0, 7, 0);
        lookup((77 << 15) | 5, 2, 1, "R9 lowest slot wins");
        wr_slot(2, 77, 3, 7, 1);
        lookup((77 << 15) | 5, 2, 0, "R9 winner protection governs");
        lookup((77 << 15) | 5, 0, 1, "R9 supervisor to lowest slot");
        // R2: rewrite moves mapping
        wr_slot(2, 500, 0, 7, 0);
        lookup(500 << 15, 3, 1, "R2 rewritten slot new page");
        lookup(77 << 15, 2, 0, "R2 R9 old page falls to next slot");
        // R10: lookup in same cycle as write sees old table
        begin
            bit ab;
            int pa;
            model(900 << 15, 0, 0, ab, pa);
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = {3'b111, 13'd900, 2'd0, 1'b0, 7'd40};
            req_valid = 1'b1;
            req_addr = 25'(900 << 15);
            req_mode = 2'b00;
            req_write = 1'b0;
            @(negedge clk);
            wr_en = 1'b0;
            req_valid = 1'b0;
            m_valid[40] = 1;
            m_lpn[40] = 900;
            m_prot[40] = 0;
            check(resp_valid && resp_abort == ab && resp_addr == 22'(pa),
                  "R10 same-cycle write unseen", int'(resp_abort), int'(ab));
        end
        lookup(900 << 15, 0, 0, "R10 write visible next lookup");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule